// File: doc/BRIEF.md
# Bit-serial accumulator packet ALU

This block is a processing node in a network of small compute nodes. It receives an execution packet as a stream of 2-bit symbols, one per accepted clock, applies the packet's leading opcode to the operand field and emits the rewritten packet on an output stream. Operands travel bit-serially. The operand field is a series of bit-slices, least significant first. Each slice holds one accumulator bit and then one bit of each operand. Only a one-bit carry, borrow or comparison state passes from one slice to the next, so no operand word is ever stored in the node.

A packet is a header marker, then the opcode list, then a separator, then the operand field, then a tail marker, then one data symbol that carries the status flag. Each opcode is OPW data symbols, least significant bit first. Slices are divided by separators. The node removes its own opcode and forwards the opcodes that follow it. It then emits the new operand field and the tail with the status flag updated. When an operation lengthens a slice, the node stalls its input for one cycle. Both sides use a valid/ready handshake.

Top module: `alu_pkt_node`

## Requirements
- R1: Symbol codes are 00 data 0, 01 data 1, 10 separator, and 11 marker, where aux=0 is a header and aux=1 is a tail. The header is forwarded. The first OPW data symbols after it form the leading opcode, LSB first, and they are removed. All later opcode symbols, the separator that ends the list, the tail and the flag symbol are forwarded in order.
- R2: After reset, out_valid is 0 and in_ready is 1. While out_valid=1 and out_ready=0, the output symbol holds and in_ready is 0. No symbol is lost or duplicated under any stall pattern on either side.
- R3: ADD (opcode 1) and SUB (opcode 2) compute acc+op1 and acc-op1 modulo 2^slices. The carry or borrow starts at 0. The first operand is removed, and the result takes the accumulator position.
- R4: AND (5), OR (6) and XOR (7) combine acc with op1 bitwise. Their result is placed the same way as in R3.
- R5: INC (3), DEC (4), NOT (8) and SHL (9) rewrite only the accumulator, in place. INC and DEC wrap around. SHL brings in 0 at the LSB and drops the MSB.
- R6: SHR (10) removes the accumulator and appends acc>>1 as the new last operand. The old first operand becomes the accumulator, and 0 enters the most significant slice. The slice count is unchanged.
- R7: CPACC (12) appends a copy of the accumulator as a new last operand. SWAP (11) exchanges op1 and op2.
- R8: DELOP (13) removes op1. OPFLUSH (14) removes every operand and keeps the accumulator.
- R9: SETEQ (16), SETGT (17) and SETLT (18) compare acc with op1 as unsigned numbers. SETZ (19) tests acc==0. Each of them removes the accumulator. The flag symbol becomes 1 when the condition holds and is passed unchanged otherwise.
- R10: COMPEQ (20), COMPGT (21) and COMPLT (22) compare op1 with op2 as unsigned numbers. They remove both operands and update the flag as in R9. The most significant differing slice decides GT and LT.
- R11: A leading opcode with any other value is treated as not implemented. Such a packet, or one with an empty opcode list, leaves the node unchanged, including the opcode and the flag.
- R12: Symbols that arrive outside a packet, before its header, are accepted and dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Node accepts the input symbol |
| in_code | input | 2 | Input symbol code |
| in_aux | input | 1 | Input marker kind (1 = tail) |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Downstream accepts the output symbol |
| out_code | output | 2 | Output symbol code |
| out_aux | output | 1 | Output marker kind (1 = tail) |

## Verification
Each operation is tested with operands that separate it from its neighbours. Additions and subtractions cover carry and borrow chains across every slice, including wrap-around. The compare cases differ in both the lowest and the highest slice, so that a wrong ordering of the magnitude state shows as a wrong flag. A flag that is already set is sent through a failing test to show that it is preserved.

The operations that lengthen or reorder a slice (CPACC, SWAP, SHR) also run under random gaps on the input and random backpressure on the output, which exercises the one-cycle input stall around each inserted symbol. Unknown opcodes, an empty opcode list and junk symbols before a header show the pass-through and drop paths at the ports.

// File: rtl/alu_pkt_pkg.sv
package alu_pkt_pkg;

  localparam logic [1:0] SYM_D0   = 2'b00;
  localparam logic [1:0] SYM_D1   = 2'b01;
  localparam logic [1:0] SYM_SEP  = 2'b10;
  localparam logic [1:0] SYM_MARK = 2'b11;

  typedef struct packed {
    logic [1:0] code;
    logic       aux;
  } sym_t;

  typedef enum logic [4:0] {
    K_NONE, K_ADD, K_SUB, K_INC, K_DEC, K_AND, K_OR, K_XOR, K_NOT,
    K_SHL, K_SHR, K_SWAP, K_CPACC, K_DELOP, K_FLUSH,
    K_SETEQ, K_SETGT, K_SETLT, K_SETZ, K_CMPEQ, K_CMPGT, K_CMPLT
  } kind_e;

  localparam int OPC_ADD   = 1;
  localparam int OPC_SUB   = 2;
  localparam int OPC_INC   = 3;
  localparam int OPC_DEC   = 4;
  localparam int OPC_AND   = 5;
  localparam int OPC_OR    = 6;
  localparam int OPC_XOR   = 7;
  localparam int OPC_NOT   = 8;
  localparam int OPC_SHL   = 9;
  localparam int OPC_SHR   = 10;
  localparam int OPC_SWAP  = 11;
  localparam int OPC_CPACC = 12;
  localparam int OPC_DELOP = 13;
  localparam int OPC_FLUSH = 14;
  localparam int OPC_SETEQ = 16;
  localparam int OPC_SETGT = 17;
  localparam int OPC_SETLT = 18;
  localparam int OPC_SETZ  = 19;
  localparam int OPC_CMPEQ = 20;
  localparam int OPC_CMPGT = 21;
  localparam int OPC_CMPLT = 22;

  localparam sym_t SEP_SYM = '{code: SYM_SEP, aux: 1'b0};

  function automatic sym_t dsym(input logic b);
    sym_t r;
    r.code = {1'b0, b};
    r.aux  = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/alu_pkt_decode.sv
module alu_pkt_decode
  import alu_pkt_pkg::*;
#(
  parameter int OPW = 5
) (
  input  logic [OPW-1:0] opc,
  output kind_e          kind,
  output logic           impl
);

  always_comb begin
    case (32'(opc))
      OPC_ADD:   kind = K_ADD;
      OPC_SUB:   kind = K_SUB;
      OPC_INC:   kind = K_INC;
      OPC_DEC:   kind = K_DEC;
      OPC_AND:   kind = K_AND;
      OPC_OR:    kind = K_OR;
      OPC_XOR:   kind = K_XOR;
      OPC_NOT:   kind = K_NOT;
      OPC_SHL:   kind = K_SHL;
      OPC_SHR:   kind = K_SHR;
      OPC_SWAP:  kind = K_SWAP;
      OPC_CPACC: kind = K_CPACC;
      OPC_DELOP: kind = K_DELOP;
      OPC_FLUSH: kind = K_FLUSH;
      OPC_SETEQ: kind = K_SETEQ;
      OPC_SETGT: kind = K_SETGT;
      OPC_SETLT: kind = K_SETLT;
      OPC_SETZ:  kind = K_SETZ;
      OPC_CMPEQ: kind = K_CMPEQ;
      OPC_CMPGT: kind = K_CMPGT;
      OPC_CMPLT: kind = K_CMPLT;
      default:   kind = K_NONE;
    endcase
    impl = (kind != K_NONE);
  end

endmodule

// File: rtl/alu_pkt_slice.sv
module alu_pkt_slice
  import alu_pkt_pkg::*;
#(
  parameter int POSW = 3
) (
  input  kind_e           kind,
  input  logic [POSW-1:0] pos,
  input  sym_t            s,
  input  logic            hold,
  input  logic            carry,
  input  logic            sep_held,
  input  logic [1:0]      mag,
  input  logic            zero,
  output logic            p1,
  output sym_t            s1,
  output logic            p2,
  output sym_t            s2,
  output logic            hold_n,
  output logic            carry_n,
  output logic            sep_held_n,
  output logic [1:0]      mag_n,
  output logic            zero_n
);

  logic b, is_data, is_sep, is_tail, at0, at1, at2;

  always_comb begin
    b       = s.code[0];
    is_data = ~s.code[1];
    is_sep  = (s.code == SYM_SEP);
    is_tail = (s.code == SYM_MARK) && s.aux;
    at0     = (pos == '0);
    at1     = (pos == POSW'(1));
    at2     = (pos == POSW'(2));
    p1 = 1'b1; s1 = s; p2 = 1'b0; s2 = s;
    hold_n = hold; carry_n = carry; sep_held_n = sep_held;
    mag_n = mag; zero_n = zero;
    if (is_data) begin
      case (kind)
        K_ADD, K_SUB, K_AND, K_OR, K_XOR: begin
          if (at0) begin
            p1 = 1'b0; hold_n = b;
          end else if (at1) begin
            case (kind)
              K_ADD: begin
                s1 = dsym(hold ^ b ^ carry);
                carry_n = (hold & b) | (hold & carry) | (b & carry);
              end
              K_SUB: begin
                s1 = dsym(hold ^ b ^ carry);
                carry_n = (~hold & b) | (~hold & carry) | (b & carry);
              end
              K_AND:   s1 = dsym(hold & b);
              K_OR:    s1 = dsym(hold | b);
              default: s1 = dsym(hold ^ b);
            endcase
          end
        end
        K_INC: if (at0) begin s1 = dsym(b ^ carry); carry_n = b & carry; end
        K_DEC: if (at0) begin s1 = dsym(b ^ carry); carry_n = ~b & carry; end
        K_NOT: if (at0) s1 = dsym(~b);
        K_SHL: if (at0) begin s1 = dsym(hold); hold_n = b; end
        K_SHR: if (at0) begin
          if (sep_held) begin
            p2 = 1'b1; s2 = SEP_SYM; sep_held_n = 1'b0;
          end else begin
            p1 = 1'b0;
          end
        end
        K_SWAP: begin
          if (at1) begin
            p1 = 1'b0; hold_n = b;
          end else if (at2) begin
            p2 = 1'b1; s2 = dsym(hold);
          end
        end
        K_CPACC: if (at0) hold_n = b;
        K_DELOP: if (at1) p1 = 1'b0;
        K_FLUSH: if (!at0) p1 = 1'b0;
        K_SETEQ, K_SETGT, K_SETLT: begin
          if (at0) begin
            p1 = 1'b0; hold_n = b;
          end else if (at1 && (hold != b)) begin
            mag_n = hold ? 2'b01 : 2'b10;
          end
        end
        K_SETZ: if (at0) begin p1 = 1'b0; zero_n = zero | b; end
        K_CMPEQ, K_CMPGT, K_CMPLT: begin
          if (at1) begin
            p1 = 1'b0; hold_n = b;
          end else if (at2) begin
            p1 = 1'b0;
            if (hold != b) mag_n = hold ? 2'b01 : 2'b10;
          end
        end
        default: ;
      endcase
    end else if (is_sep) begin
      if (kind == K_SHR) begin
        p1 = 1'b0; sep_held_n = 1'b1;
      end else if (kind == K_CPACC) begin
        s1 = dsym(hold); p2 = 1'b1; s2 = s;
      end
    end else if (is_tail) begin
      if (kind == K_SHR) begin
        s1 = dsym(1'b0); p2 = 1'b1; s2 = s;
      end else if (kind == K_CPACC) begin
        s1 = dsym(hold); p2 = 1'b1; s2 = s;
      end
    end
  end

endmodule

// File: rtl/alu_pkt_ostage.sv
module alu_pkt_ostage
  import alu_pkt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic p1,
  input  sym_t s1,
  input  logic p2,
  input  sym_t s2,
  output logic take,
  output logic out_valid,
  output sym_t out_sym,
  input  logic out_ready
);

  logic adv, pend_v;
  sym_t pend;

  assign adv  = !out_valid || out_ready;
  assign take = adv && !pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
      pend_v    <= 1'b0;
      pend      <= '0;
    end else if (adv) begin
      if (pend_v) begin
        out_sym   <= pend;
        out_valid <= 1'b1;
        pend_v    <= 1'b0;
      end else begin
        out_valid <= p1;
        if (p1) out_sym <= s1;
        pend_v <= p1 && p2;
        pend   <= s2;
      end
    end
  end

endmodule

// File: rtl/alu_pkt_node.sv
module alu_pkt_node
  import alu_pkt_pkg::*;
#(
  parameter int OPW    = 5,
  parameter int MAXOPS = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_code,
  input  logic       in_aux,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_code,
  output logic       out_aux
);

  localparam int POSW = $clog2(MAXOPS + 2);
  localparam int CNTW = $clog2(OPW + 1);
  localparam logic [POSW-1:0] POS_TOP = POSW'(MAXOPS + 1);
  localparam logic [CNTW-1:0] CNT_TOP = CNTW'(OPW - 1);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_REPLAY, S_LIST, S_OPER, S_FLAG} st_e;

  st_e             state;
  logic            thru;
  kind_e           kind;
  logic [OPW-1:0]  op_buf, op_next;
  logic [CNTW-1:0] op_cnt;
  logic [POSW-1:0] pos;
  logic            hold, carry, sep_held, zero;
  logic [1:0]      mag;

  sym_t  s_in, s1, s2, osym, sl_s1, sl_s2;
  logic  p1, p2, take, fire, cond;
  logic  is_data, is_sep, is_head, is_tail;
  kind_e dec_kind;
  logic  dec_impl;
  logic  sl_p1, sl_p2, hold_n, carry_n, sep_held_n, zero_n;
  logic [1:0] mag_n;

  assign s_in     = '{code: in_code, aux: in_aux};
  assign is_data  = ~in_code[1];
  assign is_sep   = (in_code == SYM_SEP);
  assign is_head  = (in_code == SYM_MARK) && !in_aux;
  assign is_tail  = (in_code == SYM_MARK) && in_aux;
  assign in_ready = take && (state != S_REPLAY);
  assign fire     = in_valid && in_ready;
  assign out_code = osym.code;
  assign out_aux  = osym.aux;

  alu_pkt_decode #(.OPW(OPW)) u_dec (.opc(op_next), .kind(dec_kind), .impl(dec_impl));

  alu_pkt_slice #(.POSW(POSW)) u_slice (
    .kind(kind), .pos(pos), .s(s_in), .hold(hold), .carry(carry),
    .sep_held(sep_held), .mag(mag), .zero(zero),
    .p1(sl_p1), .s1(sl_s1), .p2(sl_p2), .s2(sl_s2),
    .hold_n(hold_n), .carry_n(carry_n), .sep_held_n(sep_held_n),
    .mag_n(mag_n), .zero_n(zero_n)
  );

  alu_pkt_ostage u_out (
    .clk(clk), .rst(rst), .p1(p1), .s1(s1), .p2(p2), .s2(s2),
    .take(take), .out_valid(out_valid), .out_sym(osym), .out_ready(out_ready)
  );

  always_comb begin
    case (kind)
      K_SETEQ, K_CMPEQ: cond = (mag == 2'b00);
      K_SETGT, K_CMPGT: cond = (mag == 2'b01);
      K_SETLT, K_CMPLT: cond = (mag == 2'b10);
      K_SETZ:           cond = ~zero;
      default:          cond = 1'b0;
    endcase
  end

  always_comb begin
    op_next = op_buf;
    op_next[op_cnt] = in_code[0];
    p1 = 1'b0; p2 = 1'b0; s1 = s_in; s2 = s_in;
    case (state)
      S_IDLE:   p1 = fire && is_head;
      S_OPC:    p1 = fire && is_sep;
      S_REPLAY: begin p1 = take; s1 = dsym(op_buf[op_cnt]); end
      S_LIST:   p1 = fire;
      S_OPER: begin
        if (fire) begin
          if (thru) begin
            p1 = 1'b1;
          end else begin
            p1 = sl_p1; s1 = sl_s1; p2 = sl_p2; s2 = sl_s2;
          end
        end
      end
      S_FLAG: begin
        p1 = fire;
        if (!thru && is_data && cond) s1 = dsym(1'b1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; thru <= 1'b0; kind <= K_NONE;
      op_buf <= '0; op_cnt <= '0; pos <= '0;
      hold <= 1'b0; carry <= 1'b0; sep_held <= 1'b0; mag <= 2'b00; zero <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (fire && is_head) begin
          state <= S_OPC; thru <= 1'b0; op_buf <= '0; op_cnt <= '0;
        end
        S_OPC: if (fire) begin
          if (is_data) begin
            op_buf <= op_next;
            if (op_cnt == CNT_TOP) begin
              kind   <= dec_kind;
              op_cnt <= '0;
              if (dec_impl) begin
                state <= S_LIST;
              end else begin
                thru  <= 1'b1;
                state <= S_REPLAY;
              end
            end else begin
              op_cnt <= op_cnt + CNTW'(1);
            end
          end else if (is_sep) begin
            thru <= 1'b1; state <= S_OPER; pos <= '0;
          end
        end
        S_REPLAY: if (take) begin
          if (op_cnt == CNT_TOP) state <= S_LIST;
          else op_cnt <= op_cnt + CNTW'(1);
        end
        S_LIST: if (fire && is_sep) begin
          state <= S_OPER; pos <= '0; hold <= 1'b0; sep_held <= 1'b0;
          mag <= 2'b00; zero <= 1'b0;
          carry <= (kind == K_INC) || (kind == K_DEC);
        end
        S_OPER: if (fire) begin
          if (is_tail) state <= S_FLAG;
          if (is_sep) pos <= '0;
          else if (is_data && pos != POS_TOP) pos <= pos + POSW'(1);
          if (!thru) begin
            hold <= hold_n; carry <= carry_n; sep_held <= sep_held_n;
            mag <= mag_n; zero <= zero_n;
          end
        end
        S_FLAG: if (fire && is_data) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/alu_pkt_node_chk.sv
module alu_pkt_node_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_code,
  input logic       out_aux
);

  logic o_fire, o_head, o_tail, o_in_pkt;

  assign o_fire = out_valid && out_ready;
  assign o_head = (out_code == 2'b11) && !out_aux;
  assign o_tail = (out_code == 2'b11) && out_aux;

  always_ff @(posedge clk) begin
    if (rst) o_in_pkt <= 1'b0;
    else if (o_fire && o_head) o_in_pkt <= 1'b1;
    else if (o_fire && o_tail) o_in_pkt <= 1'b0;
  end

  p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_aux)));

  p_stall_blocks_input_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_tail_inside_pkt_r1: assert property (@(posedge clk) disable iff (rst)
    (o_fire && o_tail) |-> o_in_pkt);

  p_head_outside_pkt_r12: assert property (@(posedge clk) disable iff (rst)
    (o_fire && o_head) |-> !o_in_pkt);

endmodule

bind alu_pkt_node alu_pkt_node_chk u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_code(out_code), .out_aux(out_aux)
);

// File: tb/alu_pkt_node_bench.sv
module alu_pkt_node_bench;

  localparam int OPW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready, in_aux = 1'b0, out_valid, out_ready = 1'b1, out_aux;
  logic [1:0] in_code = 2'b00, out_code;

  always #5 clk = ~clk;

  alu_pkt_node #(.OPW(OPW), .MAXOPS(6)) u_alu_pkt_node (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_aux(in_aux), .out_valid(out_valid),
    .out_ready(out_ready), .out_code(out_code), .out_aux(out_aux)
  );

  int inq[$];
  int exq[$];
  int opq[$];
  int wq[$];
  int total = 0, bad = 0, cyc = 0, stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  string tag = "R2";

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
    end
    if (rst) begin
      in_valid = 1'b0; out_ready = 1'b1;
    end else begin
      out_ready = (stall_mode == 0) || lfsr[5] || lfsr[1];
      if (inq.size() > 0 && !(stall_mode != 0 && lfsr[0] && lfsr[3])) begin
        in_valid = 1'b1;
        in_code  = 2'(inq[0] >> 1);
        in_aux   = inq[0][0];
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (in_valid && in_ready) void'(inq.pop_front());
      if (out_valid && out_ready) begin
        total++;
        if (exq.size() == 0) begin
          bad++;
          $display("FAIL %s: got symbol %0d expected none", tag, {out_code, out_aux});
        end else begin
          int e;
          e = exq.pop_front();
          if (int'({out_code, out_aux}) != e) begin
            bad++;
            $display("FAIL %s: got symbol %0d expected %0d", tag, {out_code, out_aux}, e);
          end
        end
      end
    end
  end

  task automatic serialize(input int ops[$], input int w[$], input int f, input int width);
    exq.push_back(6);
    foreach (ops[k]) for (int b = 0; b < OPW; b++) exq.push_back(((ops[k] >> b) & 1) * 2);
    exq.push_back(4);
    for (int i = 0; i < width; i++) begin
      if (i > 0) exq.push_back(4);
      foreach (w[k]) exq.push_back(((w[k] >> i) & 1) * 2);
    end
    exq.push_back(7);
    exq.push_back(f * 2);
  endtask

  task automatic run_pkt(input string t, input int width, input int junk, input int f);
    int n[$];
    int ro[$];
    int fo, a, m, op, tmp;
    bit impl;
    tag = t;
    if (junk != 0) begin inq.push_back(0); inq.push_back(4); inq.push_back(7); inq.push_back(2); end
    inq.push_back(6);
    foreach (opq[k]) for (int b = 0; b < OPW; b++) inq.push_back(((opq[k] >> b) & 1) * 2);
    inq.push_back(4);
    for (int i = 0; i < width; i++) begin
      if (i > 0) inq.push_back(4);
      foreach (wq[k]) inq.push_back(((wq[k] >> i) & 1) * 2);
    end
    inq.push_back(7);
    inq.push_back(f * 2);
    n = wq; fo = f; m = (1 << width) - 1; a = wq[0];
    op = (opq.size() > 0) ? opq[0] : -1;
    impl = 1'b1;
    case (op)
      1:  begin n[1] = (a + n[1]) & m; n.delete(0); end
      2:  begin n[1] = (a - n[1]) & m; n.delete(0); end
      5:  begin n[1] = a & n[1]; n.delete(0); end
      6:  begin n[1] = a | n[1]; n.delete(0); end
      7:  begin n[1] = a ^ n[1]; n.delete(0); end
      3:  n[0] = (a + 1) & m;
      4:  n[0] = (a - 1) & m;
      8:  n[0] = ~a & m;
      9:  n[0] = (a << 1) & m;
      10: begin n.push_back(a >> 1); n.delete(0); end
      11: begin tmp = n[1]; n[1] = n[2]; n[2] = tmp; end
      12: n.push_back(a);
      13: n.delete(1);
      14: while (n.size() > 1) void'(n.pop_back());
      16: begin if (a == n[1]) fo = 1; n.delete(0); end
      17: begin if (a > n[1]) fo = 1; n.delete(0); end
      18: begin if (a < n[1]) fo = 1; n.delete(0); end
      19: begin if (a == 0) fo = 1; n.delete(0); end
      20: begin if (n[1] == n[2]) fo = 1; n.delete(2); n.delete(1); end
      21: begin if (n[1] > n[2]) fo = 1; n.delete(2); n.delete(1); end
      22: begin if (n[1] < n[2]) fo = 1; n.delete(2); n.delete(1); end
      default: impl = 1'b0;
    endcase
    ro = opq;
    if (impl) ro.delete(0);
    serialize(ro, n, fo, width);
    for (int c = 0; c < 4000 && (inq.size() > 0 || exq.size() > 0); c++) @(posedge clk);
    repeat (4) @(posedge clk);
    total++;
    if (exq.size() != 0) begin
      bad++;
      $display("FAIL %s: got %0d missing symbols expected 0", t, exq.size());
      exq.delete();
    end
  endtask

  task automatic pk(input string t, input int op, input int nxt, input int nw,
                    input int w0, input int w1, input int w2, input int w3,
                    input int f, input int width);
    opq.delete(); wq.delete();
    opq.push_back(op);
    if (nxt >= 0) opq.push_back(nxt);
    wq.push_back(w0);
    if (nw > 1) wq.push_back(w1);
    if (nw > 2) wq.push_back(w2);
    if (nw > 3) wq.push_back(w3);
    run_pkt(t, width, 0, f);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #3;
    total++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R2 reset: got valid=%b ready=%b expected 0 1", out_valid, in_ready);
    end
    // R1 R3: add with trailing opcodes forwarded, carry chain
    pk("R3 add", 1, 9, 3, 8'h5A, 8'hC3, 8'h11, 0, 0, 8);
    pk("R3 add wrap", 1, -1, 2, 8'hFF, 8'h01, 0, 0, 0, 8);
    pk("R3 sub", 2, 7, 3, 8'h10, 8'h01, 8'h33, 0, 1, 8);
    pk("R3 sub borrow", 2, -1, 2, 8'h00, 8'h01, 0, 0, 0, 8);
    pk("R4 and", 5, -1, 2, 8'hF0, 8'h3C, 0, 0, 0, 8);
    pk("R4 or", 6, -1, 3, 8'h81, 8'h18, 8'h7E, 0, 0, 8);
    pk("R4 xor", 7, -1, 2, 8'hAA, 8'h0F, 0, 0, 0, 8);
    pk("R5 inc wrap", 3, -1, 2, 8'hFF, 8'h12, 0, 0, 0, 8);
    pk("R5 dec wrap", 4, -1, 1, 8'h00, 0, 0, 0, 0, 8);
    pk("R5 not", 8, -1, 2, 8'h5C, 8'h77, 0, 0, 0, 8);
    pk("R5 shl", 9, -1, 2, 8'h81, 8'h44, 0, 0, 0, 8);
    pk("R6 shr", 10, -1, 3, 8'hB5, 8'h21, 8'h9C, 0, 0, 8);
    pk("R6 shr alone", 10, -1, 1, 4'hD, 0, 0, 0, 0, 4);
    pk("R7 cpacc", 12, -1, 2, 8'hC9, 8'h36, 0, 0, 0, 8);
    pk("R7 swap", 11, -1, 4, 8'h01, 8'hA5, 8'h5A, 8'hFF, 0, 8);
    pk("R8 delop", 13, -1, 3, 8'h0F, 8'hF0, 8'h3C, 0, 0, 8);
    pk("R8 flush", 14, -1, 4, 8'h42, 8'h11, 8'h22, 8'h33, 0, 8);
    pk("R9 seteq true", 16, -1, 3, 8'h6B, 8'h6B, 8'h01, 0, 0, 8);
    pk("R9 setgt msb", 17, -1, 2, 8'h80, 8'h7F, 0, 0, 0, 8);
    pk("R9 setlt false", 18, -1, 2, 8'h80, 8'h7F, 0, 0, 0, 8);
    pk("R9 setz nonzero keeps flag", 19, -1, 2, 8'h04, 8'h10, 0, 0, 1, 8);
    pk("R9 setz zero", 19, -1, 2, 8'h00, 8'h10, 0, 0, 0, 8);
    pk("R10 compeq", 20, -1, 4, 8'h11, 8'h3C, 8'h3C, 8'h99, 0, 8);
    pk("R10 compgt", 21, -1, 3, 8'h11, 8'h01, 8'hFE, 0, 0, 8);
    pk("R10 complt", 22, -1, 3, 8'h11, 8'h01, 8'hFE, 0, 0, 8);
    pk("R11 unknown opcode", 31, 1, 2, 8'h12, 8'h34, 0, 0, 1, 8);
    opq.delete(); wq.delete(); wq.push_back(8'h5A); wq.push_back(8'h01);
    run_pkt("R11 empty list", 8, 0, 0);
    opq.delete(); wq.delete(); opq.push_back(1); wq.push_back(8'h03); wq.push_back(8'h05);
    run_pkt("R12 junk before header", 8, 1, 0);
    // R2: insertion paths under random input gaps and output backpressure
    stall_mode = 1;
    pk("R2 R7 cpacc stalled", 12, 3, 3, 8'hE7, 8'h18, 8'h99, 0, 0, 8);
    pk("R2 R7 swap stalled", 11, -1, 3, 8'h01, 8'hC0, 8'h03, 0, 0, 8);
    pk("R2 R6 shr stalled", 10, -1, 2, 8'hF1, 8'h2E, 0, 0, 0, 8);
    pk("R2 R3 add stalled", 1, 12, 2, 8'h7F, 8'h7F, 0, 0, 0, 8);
    pk("R2 R11 unknown stalled", 30, -1, 2, 8'h7F, 8'h01, 0, 0, 0, 8);
    stall_mode = 0;
    summary();
  end

endmodule